// File: doc/BRIEF.md
# Hiccup Current-Limit Restart Timer

This block decides when a switching converter that keeps running into its cycle-by-cycle current limit should stop, wait, and start over. Once per switching period the sequencer gives it a strobe and a flag that says whether the current limit cut that period short. A digital accumulator stands in for the timing capacitor. A period with a limit hit adds a large step to it. A clean period takes a small step off it, and the value never goes below zero. A short burst of hits is forgotten. A sustained overload pushes the accumulator up to a trip level.

At the trip, the block raises a hiccup flag. This flag holds the gate drivers off and clears both soft-start ramps. The block then builds a long off time from eight triangular sweeps. In each sweep the accumulator climbs at the small rate to an upper bound and falls back at the same rate to a lower bound. After the eighth sweep the accumulator is cleared, the hiccup flag drops, and a one-cycle restart pulse asks the sequencer for a fresh main soft-start. All step sizes and levels are inputs, so the actual times follow from the register settings and the switching frequency.

There are three states. MONITOR integrates limit hits. RAMP_UP and RAMP_DOWN form the sweeps. There are four transitions:
- trip: MONITOR to RAMP_UP.
- crest: RAMP_UP to RAMP_DOWN.
- trough: RAMP_DOWN to RAMP_UP, taken while sweeps remain.
- release: RAMP_DOWN to MONITOR, taken after the eighth sweep.

Top module: `hiccup_restart_timer`

## Requirements
- R1: After reset, hiccup_active and restart_pulse are both low and the accumulator is zero.
- R2: In MONITOR, a strobe with ilim_hit high adds step_fast to the accumulator. The sum saturates at the all-ones value of the accumulator width.
- R3: In MONITOR, a strobe with ilim_hit low subtracts step_slow from the accumulator. The result floors at zero.
- R4: If the updated accumulator is greater than or equal to trip_level, the state moves to RAMP_UP. hiccup_active is high from the clock edge that takes that strobe.
- R5: In RAMP_UP, each strobe adds step_slow. On reaching or passing bound_high, the accumulator is set to bound_high and the state moves to RAMP_DOWN. In RAMP_DOWN, each strobe subtracts step_slow. On reaching or passing bound_low, the accumulator is set to bound_low.
- R6: Exactly eight down-sweeps end at bound_low. The eighth one clears the accumulator, returns the state to MONITOR, and raises restart_pulse for exactly one clock. hiccup_active is low during that clock. With a trip value a0 at or below bound_high, the off time therefore lasts ceil((bound_high-a0)/step_slow) + 600 strobes when the bounds are 200 and 400 and step_slow is 5.
- R7: ilim_hit has no effect while hiccup_active is high. This shows at the ports as the length of the off time.
- R8: After a release, a continuing overload trips again after the same number of strobes as from reset.
- R9: Without a strobe, the state and the accumulator hold, whatever ilim_hit does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_end | input | 1 | One-clock strobe at the end of each switching period |
| ilim_hit | input | 1 | The current limit ended this period; sampled with cycle_end |
| step_fast | input | ACC_W | Rise per period with a limit hit |
| step_slow | input | ACC_W | Decay per clean period, and the sweep step |
| trip_level | input | ACC_W | Accumulator level that starts a hiccup |
| bound_low | input | ACC_W | Lower turn point of the sweeps |
| bound_high | input | ACC_W | Upper turn point of the sweeps |
| hiccup_active | output | 1 | Holds the outputs off and clears the soft-start ramps |
| restart_pulse | output | 1 | One-clock request for a new main soft-start |

## Verification
A table of hit patterns is applied from reset, and each row's trip strobe is compared with a value worked out by hand. Solid, alternating and sparse patterns separate a correct fast/slow balance from one that ignores decay or never trips. Rows that start with clean periods expose a missing zero floor. Rows with the trip level equal to, or one above, a single step pin down the comparison at the boundary. A saturation row catches a wrapping adder. Two full off times check the sweep clamping and the sweep count: one starts from a trip value that lands exactly on the upper bound and one that overshoots it, both with ilim_hit held high. A repeat trip, a stretch with no strobe, and the single-cycle release complete the checks.

// File: rtl/hrt_pkg.sv
package hrt_pkg;
    typedef enum logic [1:0] {
        HRT_MONITOR   = 2'd0,
        HRT_RAMP_UP   = 2'd1,
        HRT_RAMP_DOWN = 2'd2
    } hrt_state_e;
endpackage

// File: rtl/hrt_step_calc.sv
// Combinational next-value arithmetic for the accumulator in every state.
module hrt_step_calc #(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             hit,
    input  logic [ACC_W-1:0] step_fast,
    input  logic [ACC_W-1:0] step_slow,
    input  logic [ACC_W-1:0] trip_level,
    input  logic [ACC_W-1:0] bound_low,
    input  logic [ACC_W-1:0] bound_high,
    output logic [ACC_W-1:0] mon_next,
    output logic             mon_trip,
    output logic [ACC_W-1:0] up_next,
    output logic             up_crest,
    output logic [ACC_W-1:0] dn_next,
    output logic             dn_trough
);
    localparam int EXT_W = ACC_W + 1;

    logic [EXT_W-1:0] sum_fast;
    logic [EXT_W-1:0] sum_slow;
    logic [EXT_W-1:0] floor_ref;

    always_comb begin
        sum_fast  = {1'b0, acc} + {1'b0, step_fast};
        sum_slow  = {1'b0, acc} + {1'b0, step_slow};
        floor_ref = {1'b0, bound_low} + {1'b0, step_slow};

        // fault integrator: fast rise with saturation, slow decay with zero floor
        if (hit) begin
            mon_next = sum_fast[ACC_W] ? {ACC_W{1'b1}} : sum_fast[ACC_W-1:0];
        end else if (acc > step_slow) begin
            mon_next = acc - step_slow;
        end else begin
            mon_next = '0;
        end
        mon_trip = (mon_next >= trip_level);

        // rising half of a sweep, clamped at the crest
        up_crest = (sum_slow >= {1'b0, bound_high});
        up_next  = up_crest ? bound_high : sum_slow[ACC_W-1:0];

        // falling half of a sweep, clamped at the trough
        dn_trough = ({1'b0, acc} <= floor_ref);
        dn_next   = dn_trough ? bound_low : (acc - step_slow);
    end
endmodule

// File: rtl/hrt_sweep_counter.sv
// Counts completed down-sweeps during one off time.
module hrt_sweep_counter #(
    parameter int NUM_SWEEPS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (NUM_SWEEPS > 1) ? $clog2(NUM_SWEEPS) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(NUM_SWEEPS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == LAST_VAL);

    AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST_VAL && inc && !clr) |=> (cnt == LAST_VAL || cnt == '0)); // R6
endmodule

// File: rtl/hiccup_restart_timer.sv
module hiccup_restart_timer
    import hrt_pkg::*;
#(
    parameter int ACC_W      = 16,
    parameter int NUM_SWEEPS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_end,
    input  logic             ilim_hit,
    input  logic [ACC_W-1:0] step_fast,
    input  logic [ACC_W-1:0] step_slow,
    input  logic [ACC_W-1:0] trip_level,
    input  logic [ACC_W-1:0] bound_low,
    input  logic [ACC_W-1:0] bound_high,
    output logic             hiccup_active,
    output logic             restart_pulse
);
    hrt_state_e       state_q, state_d;
    logic [ACC_W-1:0] acc_q, acc_d;
    logic             pulse_d;
    logic             cnt_clr, cnt_inc, cnt_last;

    logic [ACC_W-1:0] mon_next, up_next, dn_next;
    logic             mon_trip, up_crest, dn_trough;

    hrt_step_calc #(.ACC_W(ACC_W)) u_calc (
        .acc        (acc_q),
        .hit        (ilim_hit),
        .step_fast  (step_fast),
        .step_slow  (step_slow),
        .trip_level (trip_level),
        .bound_low  (bound_low),
        .bound_high (bound_high),
        .mon_next   (mon_next),
        .mon_trip   (mon_trip),
        .up_next    (up_next),
        .up_crest   (up_crest),
        .dn_next    (dn_next),
        .dn_trough  (dn_trough)
    );

    hrt_sweep_counter #(.NUM_SWEEPS(NUM_SWEEPS)) u_sweeps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .last  (cnt_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= HRT_MONITOR;
            acc_q         <= '0;
            restart_pulse <= 1'b0;
        end else begin
            state_q       <= state_d;
            acc_q         <= acc_d;
            restart_pulse <= pulse_d;
        end
    end

    // next state, accumulator and outputs
    always_comb begin
        state_d       = state_q;
        acc_d         = acc_q;
        pulse_d       = 1'b0;
        cnt_clr       = 1'b0;
        cnt_inc       = 1'b0;
        hiccup_active = (state_q != HRT_MONITOR);
        unique case (state_q)
            HRT_MONITOR: begin
                cnt_clr = 1'b1;
                if (cycle_end) begin
                    acc_d = mon_next;
                    if (mon_trip) begin
                        state_d = HRT_RAMP_UP;       // trip
                    end
                end
            end
            HRT_RAMP_UP: begin
                if (cycle_end) begin
                    acc_d = up_next;
                    if (up_crest) begin
                        state_d = HRT_RAMP_DOWN;     // crest
                    end
                end
            end
            HRT_RAMP_DOWN: begin
                if (cycle_end) begin
                    acc_d = dn_next;
                    if (dn_trough) begin
                        cnt_inc = 1'b1;
                        if (cnt_last) begin
                            state_d = HRT_MONITOR;   // release
                            acc_d   = '0;
                            pulse_d = 1'b1;
                        end else begin
                            state_d = HRT_RAMP_UP;   // trough
                        end
                    end
                end
            end
            default: begin
                state_d = HRT_MONITOR;
                acc_d   = '0;
            end
        endcase
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |=> !restart_pulse); // R6
    AST_PULSE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |-> (!hiccup_active && acc_q == '0)); // R6
    AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_pulse) |-> ($past(cnt_last) && $past(cycle_end))); // R6
    AST_TRIP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hiccup_active) |-> $past(cycle_end)); // R4
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_end |=> ($stable(acc_q) && $stable(state_q))); // R9
    AST_RAMP_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HRT_RAMP_UP && cycle_end && step_slow != '0)
            |=> (acc_q > $past(acc_q) || state_q == HRT_RAMP_DOWN)); // R5
endmodule

// File: tb/hiccup_restart_timer_tb_top.sv
module hiccup_restart_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int NVEC = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cycle_end = 1'b0;
    logic         ilim_hit = 1'b0;
    logic [W-1:0] step_fast = 16'd22;
    logic [W-1:0] step_slow = 16'd5;
    logic [W-1:0] trip_level = 16'd100;
    logic [W-1:0] bound_low = 16'd200;
    logic [W-1:0] bound_high = 16'd400;
    logic         hiccup_active;
    logic         restart_pulse;

    int n_checks = 0;
    int n_fail = 0;

    // {trip_level, hit pattern (bit0 = first strobe), expected trip strobe (0 = none in 16)}
    localparam logic [39:0] VECS [NVEC] = '{
        {16'd100, 16'hFFFF, 8'd5},   // R2 R4 solid overload
        {16'd100, 16'h5555, 8'd11},  // R2 R3 alternating
        {16'd100, 16'h1111, 8'd0},   // R3 sparse hits decay away
        {16'd100, 16'h0000, 8'd0},   // R3 clean periods only
        {16'd44,  16'h000C, 8'd4},   // R3 zero floor before first hit
        {16'd22,  16'h0001, 8'd1},   // R4 trip at equality
        {16'd23,  16'h0003, 8'd2},   // R4 one above a single step
        {16'd40,  16'h000D, 8'd4}    // R3 decay between hits
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    hiccup_restart_timer #(.ACC_W(W), .NUM_SWEEPS(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .ilim_hit(ilim_hit),
        .step_fast(step_fast), .step_slow(step_slow), .trip_level(trip_level),
        .bound_low(bound_low), .bound_high(bound_high),
        .hiccup_active(hiccup_active), .restart_pulse(restart_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycle_end = 1'b0;
        ilim_hit = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one period end; outputs are sampled at the following falling edge
    task automatic strobe(input bit hit);
        @(negedge clk);
        cycle_end = 1'b1;
        ilim_hit = hit;
        @(negedge clk);
        cycle_end = 1'b0;
        ilim_hit = 1'b0;
    endtask

    // strobes with hits until the first trip; returns strobe index or 0
    task automatic run_until_trip(input logic [15:0] pat, output int idx);
        idx = 0;
        for (int s = 0; s < 16; s++) begin
            strobe(pat[s]);
            if (hiccup_active) begin
                idx = s + 1;
                break;
            end
        end
    endtask

    // hits held during the off time; returns strobes until restart
    task automatic run_off_time(output int len, output int active_gaps);
        len = 0;
        active_gaps = 0;
        for (int s = 0; s < 2000; s++) begin
            strobe(1'b1);   // R7 hits offered while hiccup is active
            len++;
            if (restart_pulse) break;
            if (!hiccup_active) active_gaps++;
        end
    endtask

    initial begin
        int idx;
        int len;
        int gaps;

        do_reset();
        check(hiccup_active == 1'b0, "R1 hiccup_active after reset", int'(hiccup_active), 0);
        check(restart_pulse == 1'b0, "R1 restart_pulse after reset", int'(restart_pulse), 0);

        // table of patterns from reset
        for (int v = 0; v < NVEC; v++) begin
            trip_level = VECS[v][39:24];
            do_reset();
            run_until_trip(VECS[v][23:8], idx);
            check(idx == int'(VECS[v][7:0]), $sformatf("R2/R3/R4 vector %0d trip strobe", v),
                  idx, int'(VECS[v][7:0]));
        end

        // full off time, trip value 110 lands exactly on the crest: 58 + 600
        trip_level = 16'd100;
        do_reset();
        run_until_trip(16'hFFFF, idx);
        check(idx == 5, "R4 trip before off time", idx, 5);
        run_off_time(len, gaps);
        check(len == 658, "R5 R6 R7 off time length, aligned crest", len, 658);
        check(gaps == 0, "R5 hiccup_active held during off time", gaps, 0);
        check(restart_pulse == 1'b1, "R6 restart pulse at release", int'(restart_pulse), 1);
        check(hiccup_active == 1'b0, "R6 hiccup_active low with pulse", int'(hiccup_active), 0);
        @(negedge clk);
        check(restart_pulse == 1'b0, "R6 restart pulse lasts one clock", int'(restart_pulse), 0);

        // R8 overload persists: trips again after five strobes
        run_until_trip(16'hFFFF, idx);
        check(idx == 5, "R8 repeat trip after restart", idx, 5);

        // trip value 107 overshoots the crest: 59 + 600
        do_reset();
        run_until_trip(16'h5555, idx);
        check(idx == 11, "R4 alternating trip", idx, 11);
        run_off_time(len, gaps);
        check(len == 659, "R5 off time length, clamped crest", len, 659);

        // R2 saturation: 0x8000 then saturated 0xFFFF reaches trip 0xFFFF
        step_fast = 16'h8000;
        trip_level = 16'hFFFF;
        do_reset();
        run_until_trip(16'hFFFF, idx);
        check(idx == 2, "R2 saturating rise", idx, 2);
        step_fast = 16'd22;

        // R9 no strobe: hits without cycle_end leave the accumulator at zero
        trip_level = 16'd23;
        do_reset();
        @(negedge clk);
        ilim_hit = 1'b1;
        for (int c = 0; c < 50; c++) @(negedge clk);
        ilim_hit = 1'b0;
        check(hiccup_active == 1'b0, "R9 no trip without strobe", int'(hiccup_active), 0);
        run_until_trip(16'hFFFF, idx);
        check(idx == 2, "R9 accumulator held at zero", idx, 2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule